// File: doc/BRIEF.md
# Lite Timer with Input Capture

This block is a small timebase for a microcontroller-class subsystem. An 8-bit up-counter runs without stopping. It steps once every 32 cycles of the oscillator clock, through an internal prescaler, and rolls over from 255 to 0. Each rollover raises a timebase flag. A capture input pin is first brought into the clock domain by a two-flop synchronizer. A change of level in either direction then copies the running count into a capture register and raises a capture flag. While that flag is pending, further edges are discarded, so software always sees the first event since its last read.

Software reaches the block through a one-address-bit read/write port.

- **Address 0 (control/status):** holds the two interrupt enables and shows both flags. Reading this address clears the timebase flag.
- **Address 1 (capture value):** read-only. Reading it clears the capture flag.

Each flag drives its own interrupt request output, gated by its own enable. A halt input freezes the prescaler and the counter. Capture logic and register access keep working during halt.

Top module: `lt_capture_timer`

## Requirements
- R1: After reset the count is 0. It advances by exactly 1 at the end of every 32nd clock cycle in which halt is low, and wraps from 255 to 0.
- R2: While halt is high, the count and the prescaler phase hold their values. Counting resumes from the same phase when halt drops.
- R3: A rising or falling level change on cap_pin that is sampled at clock edge k loads the capture register at edge k+2. The value loaded is the count present just before edge k+2. The capture register reads at address 1.
- R4: Each accepted capture sets the capture flag, bit 1 of the control/status register at address 0.
- R5: A capture edge arriving while the capture flag is set and no capture-register read is in progress is ignored: the capture register and the flag keep their values.
- R6: A read of address 1 clears the capture flag at the next edge. Writes to address 1 change nothing.
- R7: When a capture edge is detected in the same cycle as a read of address 1, the read returns the old value, the new capture is accepted, and the flag stays set.
- R8: The timebase flag, bit 3 at address 0, is set when the count wraps from 255 to 0. A read of address 0 clears it, but a wrap in the same cycle keeps it set.
- R9: Writing address 0 loads the capture enable from bit 0 and the timebase enable from bit 2. Bits 1 and 3 are read-only and all other bits read 0.
- R10: irq_cap is high exactly when the capture flag and its enable are both set. irq_tb is high exactly when the timebase flag and its enable are both set.
- R11: With rst_n low at a clock edge, the count, prescaler, both flags, both enables and the capture register all return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Freezes the prescaler and the counter while high |
| cap_pin | input | 1 | Asynchronous capture input |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control/status, 1 capture value |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq_cap | output | 1 | Capture interrupt request |
| irq_tb | output | 1 | Timebase interrupt request |

## Verification
The bound checker watches, on every cycle, the following:

- the count steps only by +1 and never moves in a cycle after halt was high;
- the capture register stays put while the flag is pending;
- a capture-register read clears the flag, except on the collision cycle;
- a wrap always leaves the timebase flag set;
- neither request rises without its flag.

Only the bench scenarios can show:

- that the captured values match the count expected from elapsed non-halted cycles across whole wrap periods, in both edge directions;
- the exact two-edge synchronizer latency;
- that writes to the capture address have no effect;
- that enables are needed for the requests;
- that a mid-run reset clears everything.

// File: rtl/ltc_pkg.sv
// Shared definitions for the lite capture timer.
// Assumes an 8-bit register port with a single address bit.
package ltc_pkg;
    localparam int CSR_CAP_IE = 0;
    localparam int CSR_CAP_F  = 1;
    localparam int CSR_TB_IE  = 2;
    localparam int CSR_TB_F   = 3;

    typedef enum logic {
        SEL_CSR = 1'b0,
        SEL_CAP = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/ltc_prescaler.sv
// Divides the oscillator clock by DIV and emits a one-cycle tick.
// Assumes DIV >= 1; a high halt freezes the phase and suppresses the tick.
module ltc_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_nodiv
            assign tick = !halt;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            assign tick = !halt && (phase_q == LAST);

            // Advance the phase on every non-halted cycle, restarting after LAST.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (!halt)
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/ltc_counter.sv
// Free-running up-counter stepped by the prescaler tick.
// Flags the cycle in which it rolls from all ones to zero.
module ltc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    assign wrap = tick && (count == {W{1'b1}});

    // Step the count by one per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ltc_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops.
// Reports a one-cycle pulse on any level change of the synchronized value.
// Assumes STAGES >= 2.
module ltc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_det
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the pin level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[gi] <= 1'b0;
                else if (gi == 0)
                    chain_q[gi] <= pin;
                else
                    chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    // Keep the previous synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= chain_q[STAGES-1];
    end

    assign edge_det = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lt_capture_timer.sv
// Lite timer top: prescaled 8-bit counter, input capture, two flags,
// two gated interrupt requests and a one-address-bit register port.
// Assumes reads are single-cycle strobes; the clearing side effects act at the next edge.
module lt_capture_timer
    import ltc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              cap_pin,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_cap,
    output logic              irq_tb
);
    localparam logic [DATA_W-1:0] WR_MASK =
        DATA_W'((1 << CSR_CAP_IE) | (1 << CSR_TB_IE));

    logic              tick;
    logic              wrap;
    logic [DATA_W-1:0] count_q;
    logic              cap_edge;
    logic [DATA_W-1:0] cap_val_q;
    logic              cap_flag_q;
    logic              tb_flag_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              cap_rd;
    logic              csr_rd;
    logic              csr_wr;
    logic              cap_take;
    logic              cap_ie;
    logic              tb_ie;

    ltc_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .tick  (tick)
    );

    ltc_counter #(.W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count_q),
        .wrap  (wrap)
    );

    ltc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .edge_det (cap_edge)
    );

    assign cap_rd   = rd_en && (addr == SEL_CAP);
    assign csr_rd   = rd_en && (addr == SEL_CSR);
    assign csr_wr   = wr_en && (addr == SEL_CSR);
    assign cap_take = cap_edge && (!cap_flag_q || cap_rd);
    assign cap_ie   = ctrl_q[CSR_CAP_IE];
    assign tb_ie    = ctrl_q[CSR_TB_IE];

    // Capture the count on an accepted edge; otherwise a read clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val_q  <= '0;
            cap_flag_q <= 1'b0;
        end else if (cap_take) begin
            cap_val_q  <= count_q;
            cap_flag_q <= 1'b1;
        end else if (cap_rd) begin
            cap_flag_q <= 1'b0;
        end
    end

    // Set the timebase flag on wrap; a status read clears it unless a wrap coincides.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tb_flag_q <= 1'b0;
        else if (wrap)
            tb_flag_q <= 1'b1;
        else if (csr_rd)
            tb_flag_q <= 1'b0;
    end

    // Hold the writable enable bits of the control/status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (csr_wr)
            ctrl_q <= wdata & WR_MASK;
    end

    // Select the read data for the addressed register.
    always_comb begin
        rdata = '0;
        if (addr == SEL_CAP) begin
            rdata = cap_val_q;
        end else begin
            rdata            = ctrl_q & WR_MASK;
            rdata[CSR_CAP_F] = cap_flag_q;
            rdata[CSR_TB_F]  = tb_flag_q;
        end
    end

    assign irq_cap = cap_flag_q && cap_ie;
    assign irq_tb  = tb_flag_q && tb_ie;
endmodule

// File: rtl/ltc_checker.sv
// Cycle-by-cycle properties of the lite capture timer, bound to the top.
// Assumes the top's internal net names listed in the bind below.
module ltc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] cap_val,
    input logic              cap_flag,
    input logic              cap_edge,
    input logic              cap_rd,
    input logic              tb_flag,
    input logic              wrap,
    input logic              irq_cap,
    input logic              irq_tb
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> count == DATA_W'($past(count) + 1'b1));

    // R2
    cnt_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt) |-> $stable(count));

    // R4
    cap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_edge) && !$past(cap_flag) |-> cap_flag && cap_val == $past(count));

    // R5
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_flag) && !$past(cap_rd) |-> $stable(cap_val) && cap_flag);

    // R6
    cap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_rd) && !$past(cap_edge) |-> !cap_flag);

    // R7
    cap_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_rd) && $past(cap_edge) |-> cap_flag && cap_val == $past(count));

    // R8
    tb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> tb_flag);

    // R10
    irq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cap |-> cap_flag);

    // R10
    irq_tb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tb |-> tb_flag);
endmodule

bind lt_capture_timer ltc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .count    (count_q),
    .cap_val  (cap_val_q),
    .cap_flag (cap_flag_q),
    .cap_edge (cap_edge),
    .cap_rd   (cap_rd),
    .tb_flag  (tb_flag_q),
    .wrap     (wrap),
    .irq_cap  (irq_cap),
    .irq_tb   (irq_tb)
);

// File: tb/lt_capture_timer_test.sv
// Self-checking bench for the lite capture timer.
// The expected count is computed from the number of non-halted clock edges since reset.
module lt_capture_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt = 1'b0;
    logic       cap_pin = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_cap;
    logic       irq_tb;

    int checks = 0;
    int errors = 0;
    int act = 0;

    lt_capture_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt),
        .cap_pin (cap_pin),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_cap (irq_cap),
        .irq_tb  (irq_tb)
    );

    always #2 clk = ~clk;

    // Count the non-halted edges since reset: the reference for the count.
    always @(posedge clk) begin
        if (!rst_n)
            act <= 0;
        else if (!halt)
            act <= act + 1;
    end

    function automatic int model_cnt();
        return (act / 32) % 256;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic a, output int data);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        #1 data = int'(rdata);
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Toggle the pin; return the count expected in the capture register.
    task automatic capture(output int exp);
        @(negedge clk);
        cap_pin = ~cap_pin;
        @(posedge clk);
        @(posedge clk);
        #1 exp = model_cnt();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic check_reset_state(input string tag);
        int v;
        @(negedge clk);
        addr = 1'b0;
        #1 chk({tag, " R11 csr"}, int'(rdata), 0);
        addr = 1'b1;
        #1 chk({tag, " R11 capture reg"}, int'(rdata), 0);
        chk({tag, " R11 irq_cap"}, int'(irq_cap), 0);
        chk({tag, " R11 irq_tb"}, int'(irq_tb), 0);
        rd(1'b1, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: got no end expected end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        int e1;
        int e2;
        int rem;

        do_reset();
        check_reset_state("reset");

        // R1 R3 R4 R6: sweep captures over two full wrap periods, both edge directions.
        for (int i = 0; i < 40; i++) begin
            repeat (150 + i * 13) @(posedge clk);
            capture(e1);
            rd(1'b0, v);
            chk("R4 capture flag set", (v >> 1) & 1, 1);
            rd(1'b1, v);
            chk(cap_pin ? "R3 rising capture value" : "R3 falling capture value", v, e1);
            rd(1'b0, v);
            chk("R6 read clears capture flag", (v >> 1) & 1, 0);
        end

        // R5: a second edge while the flag is pending is ignored.
        capture(e1);
        repeat (100) @(posedge clk);
        capture(e2);
        rd(1'b1, v);
        chk("R5 blocked capture keeps first value", v, e1);
        rd(1'b0, v);
        chk("R5 R6 flag clear after read", (v >> 1) & 1, 0);

        // R6: writes to the capture address do nothing.
        wr(1'b1, 8'hA5);
        rd(1'b1, v);
        chk("R6 write to capture reg ignored", v, e1);
        rd(1'b0, v);
        chk("R6 write to capture reg leaves flag", (v >> 1) & 1, 0);

        // R9: only enable bits are writable.
        wr(1'b0, 8'hFF);
        rd(1'b0, v);
        chk("R9 csr write mask", v & 8'hF5, 8'h05);

        // R10: capture request follows flag and enable.
        capture(e1);
        @(negedge clk);
        chk("R10 irq_cap with enable", int'(irq_cap), 1);
        rd(1'b1, v);
        @(negedge clk);
        chk("R10 irq_cap drops after read", int'(irq_cap), 0);
        wr(1'b0, 8'h00);
        capture(e1);
        @(negedge clk);
        chk("R10 irq_cap masked by enable", int'(irq_cap), 0);

        // R7: read in the same cycle the new edge is detected.
        @(negedge clk);
        cap_pin = ~cap_pin;
        @(posedge clk);
        @(posedge clk);
        #1 e2 = model_cnt();
        @(negedge clk);
        rd_en = 1'b1;
        addr  = 1'b1;
        #1 chk("R7 colliding read returns old value", int'(rdata), e1);
        @(posedge clk);
        #1 rd_en = 1'b0;
        rd(1'b0, v);
        chk("R7 flag stays set on collision", (v >> 1) & 1, 1);
        rd(1'b1, v);
        chk("R7 new capture accepted", v, e2);

        // R8 R10: timebase flag on wrap, cleared by status read.
        rem = 8192 - (act % 8192);
        if (rem < 60) rem = rem + 8192;
        repeat (rem - 40) @(posedge clk);
        rd(1'b0, v);
        wr(1'b0, 8'h04);
        rd(1'b0, v);
        chk("R8 no timebase flag before wrap", (v >> 3) & 1, 0);
        chk("R10 irq_tb low before wrap", int'(irq_tb), 0);
        rem = 8192 - (act % 8192);
        repeat (rem + 5) @(posedge clk);
        @(negedge clk);
        chk("R10 irq_tb with enable", int'(irq_tb), 1);
        rd(1'b0, v);
        chk("R8 timebase flag after wrap", (v >> 3) & 1, 1);
        chk("R1 count wrapped to zero", model_cnt(), 0);
        rd(1'b0, v);
        chk("R8 status read clears timebase flag", (v >> 3) & 1, 0);
        chk("R10 irq_tb drops", int'(irq_tb), 0);

        // R2: halt freezes count and prescaler phase.
        repeat (17) @(posedge clk);
        @(negedge clk);
        halt = 1'b1;
        e1 = model_cnt();
        repeat (300) @(posedge clk);
        capture(e2);
        rd(1'b1, v);
        chk("R2 capture during halt", v, e2);
        chk("R2 count frozen during halt", v, e1);
        @(negedge clk);
        halt = 1'b0;
        repeat (250) @(posedge clk);
        capture(e2);
        rd(1'b1, v);
        chk("R2 count resumes with phase kept", v, e2);

        // R11: reset in mid-run clears everything.
        wr(1'b0, 8'h05);
        capture(e1);
        do_reset();
        check_reset_state("mid-run");
        repeat (70) @(posedge clk);
        capture(e1);
        rd(1'b1, v);
        chk("R1 R11 count restarts from zero", v, e1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule